// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block estimates the frequency of an intermediate-frequency signal by counting its rising edges over a known time window. One of two input pins is picked by a select bit. Each pin is brought into the local clock domain through a two-flop synchronizer. A measurement begins with a start pulse. The block then waits through a settling interval and opens a gate whose length is set by a two-bit code. While the gate is open it counts edges of the chosen pin. When the gate closes, the count is latched and a done flag is raised. All timing is derived from the block clock, which serves as the reference; one millisecond equals `REF_PER_MS` clock cycles.

The latched count is visible in parallel. It can also be moved into a shift register and read one bit at a time, most significant bit first, by a serial link outside this block. The select bit captured at start is echoed back, so the controller can confirm which input was measured.

Top module: `if_gate_counter`

## Requirements
- R1: After reset, `busy`, `done`, `sel_echo`, `rd_bit` and every bit of `count` are 0.
- R2: A `start` sampled while `busy` is 0 captures `sel` and `gate_code`, and `busy` rises on the next cycle. From then on, `sel_echo` shows the captured `sel` (0 means pin `if_a`, 1 means pin `if_b`). A `start` sampled while `busy` is 1 is ignored and changes neither the timing nor `sel_echo`.
- R3: `busy` stays high for exactly wait + gate clock cycles. The gate code maps as follows, in units of `REF_PER_MS` cycles: code 0 gives a 1 ms gate after a 1 ms wait; code 1 gives 4 ms after 1 ms; code 2 gives 8 ms after 2 ms; code 3 gives 32 ms after 2 ms.
- R4: The result equals the number of rising edges of the selected pin that occur while the gate is open. Edges during the wait interval are not counted, and neither are edges on the unselected pin.
- R5: The count saturates at all ones (2^CNT_W − 1) and does not wrap.
- R6: `done` rises in the same cycle that `busy` falls. It clears on the cycle after an accepted start. `done` and `busy` are never both 1.
- R7: `count` keeps the previous result for the whole of a new measurement and changes only when that measurement's gate closes.
- R8: `rd_load` copies `count` into the shift register, and `rd_bit` then shows bit CNT_W−1. Each cycle with `rd_shift` high (and `rd_load` low) moves the next lower bit to `rd_bit` and fills the bottom with 0. If both are high in the same cycle, `rd_load` wins.
- R9: A selected input that toggles every clock cycle (one cycle high, one cycle low) has every rising edge counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and reference clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begins a measurement when the block is idle |
| sel | input | 1 | Input select: 0 for `if_a`, 1 for `if_b` |
| gate_code | input | 2 | Gate-time code, captured at start |
| if_a | input | 1 | First signal input, asynchronous |
| if_b | input | 1 | Second signal input, asynchronous |
| rd_load | input | 1 | Loads the result into the readout shifter |
| rd_shift | input | 1 | Advances the readout shifter by one bit |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Last measurement finished |
| sel_echo | output | 1 | Select bit captured at the last accepted start |
| count | output | CNT_W | Latched edge count |
| rd_bit | output | 1 | Current serial readout bit, MSB first |

## Verification
The assertions assume that `start` is the only input that alters the measurement sequence. They also assume that `rd_load` and `rd_shift` act only on the readout shifter, so the hold and exclusivity properties can be stated on the outputs alone. The counting checks assume that each input stays low or high for at least one full clock cycle. The stimulus drives every pin from the falling clock edge, so every level lasts at least one cycle. It places the counted pulses on the selected pin strictly inside the gate, with several cycles of margin for synchronizer latency on both ends. Pulses that must be ignored end well before the gate opens.

// File: rtl/if_gate_counter.sv
module if_gate_counter #(
  parameter int CNT_W      = 20,
  parameter int REF_PER_MS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sel,
  input  logic [1:0]       gate_code,
  input  logic             if_a,
  input  logic             if_b,
  input  logic             rd_load,
  input  logic             rd_shift,
  output logic             busy,
  output logic             done,
  output logic             sel_echo,
  output logic [CNT_W-1:0] count,
  output logic             rd_bit
);

  localparam int TMR_MAX = 32 * REF_PER_MS;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_GATE} st_t;

  st_t              st;
  logic             sel_q;
  logic [1:0]       code_q;
  logic [TMR_W-1:0] tmr, wait_len, gate_len;
  logic [2:0]       sync_a, sync_b;
  logic [CNT_W-1:0] acc, acc_nx, result, sh;
  logic             rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= {sync_a[1:0], if_a};
      sync_b <= {sync_b[1:0], if_b};
    end

  assign rise = sel_q ? (sync_b[1] & ~sync_b[2]) : (sync_a[1] & ~sync_a[2]);

  always_comb begin
    case (code_q)
      2'd0:    gate_len = TMR_W'(REF_PER_MS);
      2'd1:    gate_len = TMR_W'(4 * REF_PER_MS);
      2'd2:    gate_len = TMR_W'(8 * REF_PER_MS);
      default: gate_len = TMR_W'(32 * REF_PER_MS);
    endcase
    wait_len = code_q[1] ? TMR_W'(2 * REF_PER_MS) : TMR_W'(REF_PER_MS);
  end

  assign acc_nx = (rise && acc != '1) ? acc + 1'b1 : acc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      sel_q  <= 1'b0;
      code_q <= '0;
      tmr    <= '0;
      acc    <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (start) begin
            sel_q  <= sel;
            code_q <= gate_code;
            tmr    <= '0;
            acc    <= '0;
            done   <= 1'b0;
            st     <= S_WAIT;
          end
        S_WAIT:
          if (tmr == wait_len - 1'b1) begin
            tmr <= '0;
            st  <= S_GATE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        S_GATE: begin
          acc <= acc_nx;
          if (tmr == gate_len - 1'b1) begin
            result <= acc_nx;
            done   <= 1'b1;
            st     <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        sh <= '0;
    else if (rd_load)  sh <= result;
    else if (rd_shift) sh <= {sh[CNT_W-2:0], 1'b0};

  assign busy     = (st != S_IDLE);
  assign sel_echo = sel_q;
  assign count    = result;
  assign rd_bit   = sh[CNT_W-1];

endmodule

// File: rtl/if_gate_counter_chk.sv
module if_gate_counter_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             rd_load,
  input logic             busy,
  input logic             done,
  input logic             sel_echo,
  input logic [CNT_W-1:0] count,
  input logic             rd_bit
);

  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R6
  done_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R6
  start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !done);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R2
  echo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(sel_echo)));

  // R7
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(count)));

  // R8
  load_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> (rd_bit == $past(count[CNT_W-1])));

endmodule

bind if_gate_counter if_gate_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_load(rd_load),
  .busy(busy), .done(done), .sel_echo(sel_echo), .count(count), .rd_bit(rd_bit)
);

// File: tb/sim_if_gate_counter.sv
`timescale 1ns/1ps
module sim_if_gate_counter;
  localparam int CW  = 6;
  localparam int RPM = 20;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, start = 0, sel = 0, if_a = 0, if_b = 0;
  logic rd_load = 0, rd_shift = 0;
  logic [1:0] gate_code = 0;
  logic busy, done, sel_echo, rd_bit;
  logic [CW-1:0] count;
  int nchk = 0, nfail = 0, prev = 0;

  always #4 clk = ~clk;

  if_gate_counter #(.CNT_W(CW), .REF_PER_MS(RPM)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .gate_code(gate_code),
    .if_a(if_a), .if_b(if_b), .rd_load(rd_load), .rd_shift(rd_shift),
    .busy(busy), .done(done), .sel_echo(sel_echo), .count(count), .rd_bit(rd_bit));

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gate_ms(input int c);
    return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 32;
  endfunction

  task automatic readout(input int exp);
    int bits = 0;
    @(negedge clk); rd_load = 1; rd_shift = 1;
    @(negedge clk); rd_load = 0;
    for (int i = 0; i < CW; i++) begin
      bits = (bits << 1) | int'(rd_bit);
      @(negedge clk);
    end
    chk("R8 serial word", bits, exp);
    chk("R8 zero fill", int'(rd_bit), 0);
    rd_shift = 0;
  endtask

  task automatic run(input int code, input bit s, input int n);
    int W = (code >= 2 ? 2 : 1) * RPM;
    int G = gate_ms(code) * RPM;
    int bcnt = 0, exp;
    bit sp, op;
    exp = (n > MAXC) ? MAXC : n;
    @(negedge clk); sel = s; gate_code = 2'(code); start = 1;
    for (int t = 1; t <= W + G + 3; t++) begin
      @(negedge clk);
      start = 0; sel = s; gate_code = 2'(code);
      if (busy) bcnt++;
      if (t == 1) chk("R6 done cleared", int'(done), 0);
      if (t == 5) begin start = 1; sel = ~s; gate_code = ~2'(code); end
      if (t == W + G - 2) chk("R7 count held", int'(count), prev);
      sp = 0;
      if (t >= 2 && t <= W - 4) sp = t[0];
      if (t >= W + 3 && t < W + 3 + 2 * n) sp = ((t - W - 3) % 2 == 0);
      op = t[0];
      if (s) begin if_b = sp; if_a = op; end
      else   begin if_a = sp; if_b = op; end
    end
    if_a = 0; if_b = 0;
    chk("R3 busy length", bcnt, W + G);
    chk("R6 done after close", int'(done), 1);
    chk("R6 busy low", int'(busy), 0);
    chk("R2 sel echo", int'(sel_echo), int'(s));
    if (n > MAXC) chk("R5 saturated count", int'(count), exp);
    else          chk("R4 R9 edge count", int'(count), exp);
    readout(exp);
    prev = exp;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 count", int'(count), 0);
    chk("R1 sel_echo", int'(sel_echo), 0);
    chk("R1 rd_bit", int'(rd_bit), 0);
    rst_n = 1;
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 2; s++) begin
        int nmax = (gate_ms(c) * RPM - 8) / 2;
        run(c, s[0], 0);
        run(c, s[0], 3);
        run(c, s[0], nmax);
      end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule